// File: doc/BRIEF.md
# Message Object Receive Interrupt Controller

This block keeps the receive-interrupt state for the message objects of a CAN acceptance-filter gateway. The gateway pulses a receive strobe with the number of the object that has just been written. The CPU pulses a read strobe with the number of the object it has just drained. For each object, the block holds a pending flag and a lost-message flag. It raises one combined interrupt request towards the system interrupt controller. Objects can be enabled one by one, and a single global enable gates the combined request.

Each interrupt-capable object is a three-state machine. `OBJ_EMPTY` means nothing is pending. `OBJ_FRESH` means one message is pending. `OBJ_LOST` means a message is pending and at least one earlier message was overwritten before it was read. The transitions are:

- `T_ARRIVE`: `OBJ_EMPTY` to `OBJ_FRESH`, on an enabled receive.
- `T_OVERRUN`: `OBJ_FRESH` to `OBJ_LOST`, on an enabled receive.
- `T_OVERRUN_AGAIN`: `OBJ_LOST` to `OBJ_LOST`, on an enabled receive.
- `T_SERVICE`: `OBJ_FRESH` or `OBJ_LOST` to `OBJ_EMPTY`, on a read.
- `T_SERVICE_REFILL`: `OBJ_FRESH` or `OBJ_LOST` to `OBJ_FRESH`, on a read that coincides with an enabled receive.

The output stage is a two-state machine. It moves from `IRQ_QUIET` to `IRQ_RAISED` with `T_IRQ_SET` and back with `T_IRQ_CLEAR`.

Only objects 0 to 63 take part in interrupts. The index fields are 8 bits wide, so receive events for higher-numbered objects (the table holds up to 146) are accepted and have no effect here. Software picks the object to serve from the pending vector. The pending vector is read as two 32-bit words, and the lost flags are read the same way.

Top module: `msgirq_ctrl`

## Requirements
- R1: A receive strobe for object k (0 to 63) whose enable is set sets pending bit k. Bit k appears at bit position k mod 32 of the word chosen by word_sel_i = k / 32, where 0 selects objects 0 to 31 and 1 selects objects 32 to 63. The bit is visible in the cycle after the strobe edge.
- R2: A receive strobe with an index of 64 or above changes no pending flag, no lost flag and the interrupt output.
- R3: A receive strobe for an object whose per-object enable is clear sets neither its pending flag nor its lost flag.
- R4: A receive strobe for an enabled object whose pending flag is already set sets that object's lost flag, and the pending flag stays set.
- R5: A read strobe for object k clears both its pending flag and its lost flag.
- R6: When a read strobe and an enabled receive strobe name the same object in the same cycle, the pending flag ends set and the lost flag ends clear.
- R7: irq_o is a register. After each clock edge it equals the OR of all pending flags, ANDed with the global enable, as they were before that edge.
- R8: While the global enable is clear, irq_o stays low even when flags are pending.
- R9: Reset clears every pending flag, every lost flag, every per-object enable, the global enable and irq_o.
- R10: Clearing an object's enable leaves an already-set pending flag set until the object is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_evt_i | input | 1 | One-cycle strobe: a message was stored in an object |
| rx_idx_i | input | 8 | Index of the object that was written (0 to 255) |
| rd_evt_i | input | 1 | One-cycle strobe: the CPU has read an object |
| rd_idx_i | input | 8 | Index of the object that was read |
| en_wr_i | input | 1 | Write strobe for one per-object enable |
| en_idx_i | input | 8 | Object whose enable is written |
| en_val_i | input | 1 | New enable value |
| gbl_wr_i | input | 1 | Write strobe for the global enable |
| gbl_val_i | input | 1 | New global enable value |
| word_sel_i | input | 1 | Readout word: 0 for objects 0 to 31, 1 for objects 32 to 63 |
| pend_word_o | output | 32 | Pending flags of the selected word |
| lost_word_o | output | 32 | Lost-message flags of the selected word |
| irq_o | output | 1 | Combined receive interrupt request |

## Verification
The assertions assume that every strobe lasts one clock cycle and that its index is valid in that same cycle. They also assume that inputs do not change close to the active edge. The stimulus drives every strobe and index on the falling edge and removes it on the next falling edge, so each event is seen at exactly one rising edge. High indices are used only as receive events, so that the checks on out-of-range indices see no pending change from any other source. Coincident read and receive strobes are issued only for the same object. This makes the rule that the receive wins the only one in play.

// File: rtl/msgirq_pkg.sv
package msgirq_pkg;

    // Per-object receive state. Bit 0 is the pending flag, bit 1 the lost flag.
    typedef enum logic [1:0] {
        OBJ_EMPTY = 2'b00,
        OBJ_FRESH = 2'b01,
        OBJ_LOST  = 2'b11
    } obj_state_t;

    // Combined request stage.
    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;

endpackage

// File: rtl/msgirq_obj_fsm.sv
module msgirq_obj_fsm
    import msgirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_hit_i,
    input  logic rd_hit_i,
    input  logic obj_en_i,
    output logic pend_o,
    output logic lost_o
);

    obj_state_t state_q;
    obj_state_t state_d;
    logic       take;

    assign take = rx_hit_i & obj_en_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OBJ_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OBJ_EMPTY: begin
                if (take) begin
                    state_d = OBJ_FRESH;                  // T_ARRIVE
                end
            end
            OBJ_FRESH: begin
                if (rd_hit_i) begin
                    state_d = take ? OBJ_FRESH : OBJ_EMPTY; // T_SERVICE_REFILL / T_SERVICE
                end else if (take) begin
                    state_d = OBJ_LOST;                   // T_OVERRUN
                end
            end
            OBJ_LOST: begin
                if (rd_hit_i) begin
                    state_d = take ? OBJ_FRESH : OBJ_EMPTY; // T_SERVICE_REFILL / T_SERVICE
                end else begin
                    state_d = OBJ_LOST;                   // T_OVERRUN_AGAIN or hold
                end
            end
            default: begin
                state_d = OBJ_EMPTY;
            end
        endcase
    end

    // Outputs
    always_comb begin
        pend_o = 1'b0;
        lost_o = 1'b0;
        unique case (state_q)
            OBJ_EMPTY: begin
                pend_o = 1'b0;
                lost_o = 1'b0;
            end
            OBJ_FRESH: begin
                pend_o = 1'b1;
                lost_o = 1'b0;
            end
            OBJ_LOST: begin
                pend_o = 1'b1;
                lost_o = 1'b1;
            end
            default: begin
                pend_o = 1'b0;
                lost_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/msgirq_enable_bank.sv
module msgirq_enable_bank #(
    parameter int NUM_OBJ = 64,
    parameter int IDX_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_wr_i,
    input  logic [IDX_W-1:0]   en_idx_i,
    input  logic               en_val_i,
    input  logic               gbl_wr_i,
    input  logic               gbl_val_i,
    output logic [NUM_OBJ-1:0] obj_en_o,
    output logic               gbl_en_o
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_OBJ; gi++) begin : g_en
            logic sel;
            assign sel = en_wr_i && (en_idx_i == IDX_W'(gi));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    obj_en_o[gi] <= 1'b0;
                end else if (sel) begin
                    obj_en_o[gi] <= en_val_i;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gbl_en_o <= 1'b0;
        end else if (gbl_wr_i) begin
            gbl_en_o <= gbl_val_i;
        end
    end

endmodule

// File: rtl/msgirq_irq_out.sv
module msgirq_irq_out
    import msgirq_pkg::*;
#(
    parameter int NUM_OBJ = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OBJ-1:0] pend_i,
    input  logic               gbl_en_i,
    output logic               irq_o
);

    irq_state_t state_q;
    irq_state_t state_d;
    logic       want;

    assign want = (|pend_i) & gbl_en_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (want)  state_d = IRQ_RAISED;  // T_IRQ_SET
            IRQ_RAISED: if (!want) state_d = IRQ_QUIET;   // T_IRQ_CLEAR
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        unique case (state_q)
            IRQ_RAISED: irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/msgirq_readout.sv
module msgirq_readout #(
    parameter int NUM_OBJ = 64,
    parameter int WORD_W  = 32,
    parameter int SEL_W   = 1
) (
    input  logic [NUM_OBJ-1:0] pend_i,
    input  logic [NUM_OBJ-1:0] lost_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic [WORD_W-1:0]  pend_word_o,
    output logic [WORD_W-1:0]  lost_word_o
);

    localparam int NUM_WORDS = NUM_OBJ / WORD_W;

    logic [WORD_W-1:0] pw [NUM_WORDS];
    logic [WORD_W-1:0] lw [NUM_WORDS];

    genvar gw;
    generate
        for (gw = 0; gw < NUM_WORDS; gw++) begin : g_word
            assign pw[gw] = pend_i[gw*WORD_W +: WORD_W];
            assign lw[gw] = lost_i[gw*WORD_W +: WORD_W];
        end
    endgenerate

    assign pend_word_o = pw[sel_i];
    assign lost_word_o = lw[sel_i];

endmodule

// File: rtl/msgirq_ctrl.sv
module msgirq_ctrl #(
    parameter int NUM_IRQ_OBJ = 64,
    parameter int IDX_W       = 8,
    parameter int WORD_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_evt_i,
    input  logic [IDX_W-1:0]  rx_idx_i,
    input  logic              rd_evt_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    input  logic              en_wr_i,
    input  logic [IDX_W-1:0]  en_idx_i,
    input  logic              en_val_i,
    input  logic              gbl_wr_i,
    input  logic              gbl_val_i,
    input  logic              word_sel_i,
    output logic [WORD_W-1:0] pend_word_o,
    output logic [WORD_W-1:0] lost_word_o,
    output logic              irq_o
);

    logic [NUM_IRQ_OBJ-1:0] pend_vec;
    logic [NUM_IRQ_OBJ-1:0] lost_vec;
    logic [NUM_IRQ_OBJ-1:0] obj_en;
    logic                   gbl_en;

    msgirq_enable_bank #(
        .NUM_OBJ (NUM_IRQ_OBJ),
        .IDX_W   (IDX_W)
    ) u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_wr_i   (en_wr_i),
        .en_idx_i  (en_idx_i),
        .en_val_i  (en_val_i),
        .gbl_wr_i  (gbl_wr_i),
        .gbl_val_i (gbl_val_i),
        .obj_en_o  (obj_en),
        .gbl_en_o  (gbl_en)
    );

    // Index decode: indices at or above NUM_IRQ_OBJ match no object.
    genvar go;
    generate
        for (go = 0; go < NUM_IRQ_OBJ; go++) begin : g_obj
            logic rx_hit;
            logic rd_hit;
            assign rx_hit = rx_evt_i && (rx_idx_i == IDX_W'(go));
            assign rd_hit = rd_evt_i && (rd_idx_i == IDX_W'(go));
            msgirq_obj_fsm u_fsm (
                .clk      (clk),
                .rst_n    (rst_n),
                .rx_hit_i (rx_hit),
                .rd_hit_i (rd_hit),
                .obj_en_i (obj_en[go]),
                .pend_o   (pend_vec[go]),
                .lost_o   (lost_vec[go])
            );
        end
    endgenerate

    msgirq_irq_out #(
        .NUM_OBJ (NUM_IRQ_OBJ)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (pend_vec),
        .gbl_en_i (gbl_en),
        .irq_o    (irq_o)
    );

    msgirq_readout #(
        .NUM_OBJ (NUM_IRQ_OBJ),
        .WORD_W  (WORD_W),
        .SEL_W   (1)
    ) u_rd (
        .pend_i      (pend_vec),
        .lost_i      (lost_vec),
        .sel_i       (word_sel_i),
        .pend_word_o (pend_word_o),
        .lost_word_o (lost_word_o)
    );

endmodule

// File: rtl/msgirq_ctrl_chk.sv
module msgirq_ctrl_chk #(
    parameter int NUM_IRQ_OBJ = 64,
    parameter int IDX_W       = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rx_evt_i,
    input logic [IDX_W-1:0]       rx_idx_i,
    input logic                   rd_evt_i,
    input logic [IDX_W-1:0]       rd_idx_i,
    input logic                   irq_o,
    input logic [NUM_IRQ_OBJ-1:0] pend_vec,
    input logic [NUM_IRQ_OBJ-1:0] lost_vec,
    input logic [NUM_IRQ_OBJ-1:0] obj_en,
    input logic                   gbl_en
);

    localparam int OBJ_W = $clog2(NUM_IRQ_OBJ);

    logic [OBJ_W-1:0] rx_q;
    logic [OBJ_W-1:0] rd_q;
    logic             rx_ok;
    logic             rd_ok;

    assign rx_ok = rx_idx_i < IDX_W'(NUM_IRQ_OBJ);
    assign rd_ok = rd_idx_i < IDX_W'(NUM_IRQ_OBJ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
            rd_q <= '0;
        end else begin
            rx_q <= rx_idx_i[OBJ_W-1:0];
            rd_q <= rd_idx_i[OBJ_W-1:0];
        end
    end

    assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past((|pend_vec) & gbl_en)));

    assert_gbl_gates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gbl_en |=> !irq_o);

    assert_high_idx_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt_i && !rx_ok && !rd_evt_i) |=>
            (pend_vec == $past(pend_vec)) && (lost_vec == $past(lost_vec)));

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt_i && rd_ok && !(rx_evt_i && rx_idx_i == rd_idx_i)) |=>
            (!pend_vec[rd_q] && !lost_vec[rd_q]));

    assert_overrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt_i && rx_ok && obj_en[rx_idx_i[OBJ_W-1:0]] && pend_vec[rx_idx_i[OBJ_W-1:0]]
            && !(rd_evt_i && rd_idx_i == rx_idx_i)) |=>
            (lost_vec[rx_q] && pend_vec[rx_q]));

endmodule

bind msgirq_ctrl msgirq_ctrl_chk #(
    .NUM_IRQ_OBJ (NUM_IRQ_OBJ),
    .IDX_W       (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_evt_i (rx_evt_i),
    .rx_idx_i (rx_idx_i),
    .rd_evt_i (rd_evt_i),
    .rd_idx_i (rd_idx_i),
    .irq_o    (irq_o),
    .pend_vec (pend_vec),
    .lost_vec (lost_vec),
    .obj_en   (obj_en),
    .gbl_en   (gbl_en)
);

// File: tb/msgirq_ctrl_tb.sv
`timescale 1ns/1ps
module msgirq_ctrl_tb;

    localparam int IW = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_evt_i, rd_evt_i, en_wr_i, en_val_i, gbl_wr_i, gbl_val_i, word_sel_i;
    logic [IW-1:0] rx_idx_i, rd_idx_i, en_idx_i;
    logic [31:0] pend_word_o, lost_word_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    msgirq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .rx_evt_i(rx_evt_i), .rx_idx_i(rx_idx_i),
        .rd_evt_i(rd_evt_i), .rd_idx_i(rd_idx_i),
        .en_wr_i(en_wr_i), .en_idx_i(en_idx_i), .en_val_i(en_val_i),
        .gbl_wr_i(gbl_wr_i), .gbl_val_i(gbl_val_i),
        .word_sel_i(word_sel_i),
        .pend_word_o(pend_word_o), .lost_word_o(lost_word_o),
        .irq_o(irq_o)
    );

    // op: 0 receive, 1 read, 2 receive and read on the same object
    typedef struct packed {
        logic [1:0] op;
        logic [7:0] idx;
        logic       p;
        logic       l;
    } vec_t;

    localparam vec_t VEC [16] = '{
        '{2'd0, 8'd5,  1'b1, 1'b0},   // R1 first arrival
        '{2'd0, 8'd5,  1'b1, 1'b1},   // R4 overwrite
        '{2'd1, 8'd5,  1'b0, 1'b0},   // R5 read clears both
        '{2'd0, 8'd40, 1'b1, 1'b0},   // R1 upper word
        '{2'd0, 8'd40, 1'b1, 1'b1},   // R4
        '{2'd2, 8'd40, 1'b1, 1'b0},   // R6 receive wins
        '{2'd1, 8'd40, 1'b0, 1'b0},   // R5
        '{2'd0, 8'd63, 1'b1, 1'b0},   // R1 top index
        '{2'd0, 8'd0,  1'b1, 1'b0},   // R1 bottom index
        '{2'd1, 8'd63, 1'b0, 1'b0},   // R5
        '{2'd1, 8'd0,  1'b0, 1'b0},   // R5
        '{2'd0, 8'd31, 1'b1, 1'b0},   // R1 word edge
        '{2'd0, 8'd32, 1'b1, 1'b0},   // R1 word edge
        '{2'd2, 8'd32, 1'b1, 1'b0},   // R6 without prior loss
        '{2'd1, 8'd31, 1'b0, 1'b0},   // R5
        '{2'd1, 8'd32, 1'b0, 1'b0}    // R5
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic peek(input int idx, output logic p, output logic l);
        word_sel_i = 1'(idx / 32);
        #1;
        p = pend_word_o[idx % 32];
        l = lost_word_o[idx % 32];
    endtask

    task automatic op(input int kind, input int idx);
        @(negedge clk);
        rx_evt_i = (kind == 0 || kind == 2);
        rd_evt_i = (kind == 1 || kind == 2);
        rx_idx_i = IW'(idx);
        rd_idx_i = IW'(idx);
        @(negedge clk);
        rx_evt_i = 1'b0;
        rd_evt_i = 1'b0;
    endtask

    task automatic set_en(input int idx, input logic v);
        @(negedge clk);
        en_wr_i = 1'b1; en_idx_i = IW'(idx); en_val_i = v;
        @(negedge clk);
        en_wr_i = 1'b0;
    endtask

    task automatic set_gbl(input logic v);
        @(negedge clk);
        gbl_wr_i = 1'b1; gbl_val_i = v;
        @(negedge clk);
        gbl_wr_i = 1'b0;
    endtask

    task automatic both_words(input string req, input logic [31:0] e0, input logic [31:0] e1);
        word_sel_i = 1'b0; #1;
        chk(req, pend_word_o, e0);
        chk(req, lost_word_o, 32'h0);
        word_sel_i = 1'b1; #1;
        chk(req, pend_word_o, e1);
        chk(req, lost_word_o, 32'h0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic p, l;
        rst_n = 1'b0;
        rx_evt_i = 0; rd_evt_i = 0; en_wr_i = 0; en_val_i = 0;
        gbl_wr_i = 0; gbl_val_i = 0; word_sel_i = 0;
        rx_idx_i = '0; rd_idx_i = '0; en_idx_i = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        both_words("R9 reset", 32'h0, 32'h0);
        chk("R9 irq at reset", 32'(irq_o), 32'h0);
        rst_n = 1'b1;

        // R3 / R9: enables come out of reset cleared
        op(0, 3);
        peek(3, p, l);
        chk("R3 disabled object no pending", 32'(p), 32'h0);
        chk("R3 disabled object no lost", 32'(l), 32'h0);

        for (int i = 0; i < 64; i++) set_en(i, 1'b1);

        // R8: pending without global enable keeps irq low
        op(0, 7);
        peek(7, p, l);
        chk("R1 pending obj 7", 32'(p), 32'h1);
        @(negedge clk);
        chk("R8 irq gated off", 32'(irq_o), 32'h0);
        // R7: global on, irq one cycle after the enable register
        set_gbl(1'b1);
        chk("R7 irq not yet", 32'(irq_o), 32'h0);
        @(negedge clk);
        chk("R7 irq raised", 32'(irq_o), 32'h1);
        op(1, 7);
        chk("R7 irq lags clear", 32'(irq_o), 32'h1);
        @(negedge clk);
        chk("R7 irq dropped", 32'(irq_o), 32'h0);

        // Vector table
        foreach (VEC[k]) begin
            op(int'(VEC[k].op), int'(VEC[k].idx));
            peek(int'(VEC[k].idx), p, l);
            chk($sformatf("R1/R4/R5/R6 vec %0d pending", k), 32'(p), 32'(VEC[k].p));
            chk($sformatf("R1/R4/R5/R6 vec %0d lost", k), 32'(l), 32'(VEC[k].l));
        end
        @(negedge clk);
        chk("R7 irq low when all served", 32'(irq_o), 32'h0);

        // R2: high indices are inert
        op(0, 64);
        op(0, 145);
        op(0, 255);
        both_words("R2 high index", 32'h0, 32'h0);
        @(negedge clk);
        chk("R2 irq stays low", 32'(irq_o), 32'h0);

        // R10 / R3: disable after arrival keeps pending, blocks further arrivals
        op(0, 9);
        set_en(9, 1'b0);
        peek(9, p, l);
        chk("R10 pending kept after disable", 32'(p), 32'h1);
        op(0, 9);
        peek(9, p, l);
        chk("R3 disabled receive sets no lost", 32'(l), 32'h0);
        chk("R10 still pending", 32'(p), 32'h1);
        op(1, 9);
        peek(9, p, l);
        chk("R5 read of disabled object", 32'(p), 32'h0);

        // R9: mid-run reset clears flags, enables and global enable
        op(0, 20);
        op(0, 20);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        both_words("R9 mid-run reset", 32'h0, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        op(0, 20);
        peek(20, p, l);
        chk("R9 enable cleared by reset", 32'(p), 32'h0);
        set_en(20, 1'b1);
        op(0, 20);
        @(negedge clk);
        chk("R9 global cleared by reset", 32'(irq_o), 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule